// File: doc/BRIEF.md
# Phase-Frequency Detector with Anti-Backlash Clear

This block is the digital comparator at the front of a frequency synthesizer loop. It watches a reference input and a divided-down feedback input, both asynchronous to a fast sampling clock. It turns their rising edges into two enables for a charge pump. The `up` enable asks for positive current and speeds the oscillator up. The `dn` enable asks for negative current and slows it down. When both enables are low, the pump is in high impedance and delivers no net current.

Each enable is a sticky flag that a rising edge on its own input sets. The flags are cleared only after both of them have been high for a programmable number of sampling cycles. This window is the anti-backlash pulse. Because of it, inputs that are perfectly in phase still produce matched, equal-width pulses on both enables instead of nothing, and the loop has no dead zone near lock.

A lock indicator counts finished comparisons in which neither enable stayed high longer than the window plus a tolerance. The indicator asserts after a programmable run of such comparisons and drops on the first one that breaks the rule.

Top module: `pfd_antibacklash`

## Requirements
- R1: A synchronous active-high `rst` forces `up`, `dn` and `locked` low on the next clock edge, and they stay low while it is held.
- R2: Each input passes through two synchronizer flops. A 0-to-1 change of `ref_in` that is present at clock edge k makes `up` read 1 after edge k+2. `fb_in` sets `dn` with the same timing. Encoding: `up`=1,`dn`=0 sources current; `up`=0,`dn`=1 sinks current; both 0 is high impedance.
- R3: Once both enables are high, both stay high for exactly E cycles and then clear together. E = `dly_cycles`, except that a value of 0 is treated as 1. Both enables are never high together for more than E consecutive cycles.
- R4: Inputs that rise in the same cycle produce pulses of width E on `up` and on `dn` in every period.
- R5: At equal frequencies, a reference that leads by L cycles gives `up` pulses of L+E cycles and `dn` pulses of E cycles. A reference that lags by L cycles gives the mirror image.
- R6: When the reference runs at several times the feedback frequency, `up` is high for most of the run and `dn` only briefly.
- R7: Rising edges that arrive while the clear window is running, other than in its final cycle, have no effect: once the window ends, the enables stay low until a fresh edge arrives.
- R8: A rising edge detected in the cycle in which the clear completes is not lost. Its enable reads 0 for one cycle and then 1.
- R9: `locked` rises at the end of the T-th consecutive clear with no violation, where T = `lock_span` and a value of 0 is treated as 1. A violation is any cycle in which an enable has already been high for at least E + `lock_tol` cycles and is still high.
- R10: A violation resets the good-comparison count, and `locked` reads 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference input, asynchronous |
| fb_in | input | 1 | Divided feedback input, asynchronous |
| dly_cycles | input | DLY_W | Anti-backlash window in clock cycles (0 acts as 1); change only during reset |
| lock_tol | input | DLY_W | Extra cycles an enable may stay high beyond the window |
| lock_span | input | LOCK_W | Good comparisons needed before lock (0 acts as 1) |
| up | output | 1 | Charge pump source enable |
| dn | output | 1 | Charge pump sink enable |
| locked | output | 1 | Lock indication |

## Verification
Several rules are checked by the assertions on every cycle. Each rise of an enable must trace back to a detected input edge or a held-over edge. A clear may fire only while both enables are high, and both read low after it. The overlap of the two enables never exceeds the window. A held-over edge re-raises its enable. A violation drops `locked`. Pulse widths as a function of phase lead or lag, the dominance of `up` when the reference runs fast, the masking of edges inside the window, and the moment lock is reached can only be shown by the bench's scenarios, checked against its reference model cycle by cycle.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Anti-backlash window: a request of zero still yields one cycle.
  function automatic int unsigned win_len(input int unsigned req);
    return (req == 0) ? 1 : req;
  endfunction

  // Longest legal run of one enable before it counts as a violation.
  function automatic int unsigned run_cap(input int unsigned win, input int unsigned tol);
    return win + tol;
  endfunction

  // Number of good comparisons needed for lock: zero acts as one.
  function automatic int unsigned lock_goal(input int unsigned span);
    return (span == 0) ? 1 : span;
  endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_o
);
  logic [SYNC_STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[SYNC_STAGES-1:0], din};
  end

  assign rise_o = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
endmodule

// File: rtl/pfd_flag.sv
module pfd_flag (
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  input  logic busy_i,
  input  logic clr_i,
  output logic flag_o,
  output logic held_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      held_o <= 1'b0;
    end else begin
      held_o <= rise_i & clr_i;
      if (clr_i) flag_o <= 1'b0;
      else       flag_o <= flag_o | held_o | (rise_i & ~busy_i);
    end
  end
endmodule

// File: rtl/pfd_clear_timer.sv
module pfd_clear_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             both_i,
  input  logic [DLY_W-1:0] win_i,
  output logic             clr_o,
  output logic             busy_o
);
  logic [DLY_W-1:0] left;
  logic             one_cycle;

  assign one_cycle = (win_i == DLY_W'(1));
  assign clr_o     = busy_o ? (left == DLY_W'(1)) : (both_i & one_cycle);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      left   <= '0;
    end else if (busy_o) begin
      left <= left - DLY_W'(1);
      if (left == DLY_W'(1)) busy_o <= 1'b0;
    end else if (both_i && !one_cycle) begin
      busy_o <= 1'b1;
      left   <= win_i - DLY_W'(1);
    end
  end
endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
  parameter int DLY_W  = 8,
  parameter int LOCK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_i,
  input  logic              dn_i,
  input  logic              clr_i,
  input  logic [DLY_W-1:0]  win_i,
  input  logic [DLY_W-1:0]  tol_i,
  input  logic [LOCK_W-1:0] span_i,
  output logic              viol_o,
  output logic              locked_o
);
  import pfd_pkg::*;

  localparam int RUN_W = DLY_W + 2;

  logic [RUN_W-1:0]  run_up, run_dn, cap;
  logic [LOCK_W-1:0] good, goal, good_nxt;

  assign cap    = RUN_W'(run_cap(32'(win_i), 32'(tol_i)));
  assign goal   = LOCK_W'(lock_goal(32'(span_i)));
  assign viol_o = (up_i && run_up >= cap) || (dn_i && run_dn >= cap);
  assign good_nxt = (good < goal) ? good + LOCK_W'(1) : good;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_up <= '0;
      run_dn <= '0;
    end else begin
      run_up <= !up_i ? '0 : ((run_up != '1) ? run_up + RUN_W'(1) : run_up);
      run_dn <= !dn_i ? '0 : ((run_dn != '1) ? run_dn + RUN_W'(1) : run_dn);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      good     <= '0;
      locked_o <= 1'b0;
    end else if (viol_o) begin
      good     <= '0;
      locked_o <= 1'b0;
    end else if (clr_i) begin
      good     <= good_nxt;
      locked_o <= (good_nxt >= goal);
    end
  end
endmodule

// File: rtl/pfd_antibacklash.sv
module pfd_antibacklash #(
  parameter int DLY_W       = 8,
  parameter int LOCK_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_in,
  input  logic              fb_in,
  input  logic [DLY_W-1:0]  dly_cycles,
  input  logic [DLY_W-1:0]  lock_tol,
  input  logic [LOCK_W-1:0] lock_span,
  output logic              up,
  output logic              dn,
  output logic              locked
);
  import pfd_pkg::*;

  localparam int NCH = 2;  // channel 0: reference -> up, channel 1: feedback -> dn

  logic [NCH-1:0] raw_v, rise_v, flag_v, held_v;
  logic           ref_edge, fb_edge, pend_up, pend_dn;
  logic           clr_evt, busy, lock_viol;
  logic [DLY_W-1:0] eff_dly;

  assign raw_v   = {fb_in, ref_in};
  assign eff_dly = DLY_W'(win_len(32'(dly_cycles)));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    pfd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .din(raw_v[ch]), .rise_o(rise_v[ch])
    );
    pfd_flag u_flag (
      .clk(clk), .rst(rst), .rise_i(rise_v[ch]), .busy_i(busy),
      .clr_i(clr_evt), .flag_o(flag_v[ch]), .held_o(held_v[ch])
    );
  end

  assign ref_edge = rise_v[0];
  assign fb_edge  = rise_v[1];
  assign pend_up  = held_v[0];
  assign pend_dn  = held_v[1];
  assign up       = flag_v[0];
  assign dn       = flag_v[1];

  pfd_clear_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst(rst), .both_i(up & dn), .win_i(eff_dly),
    .clr_o(clr_evt), .busy_o(busy)
  );

  pfd_lock_det #(.DLY_W(DLY_W), .LOCK_W(LOCK_W)) u_lock (
    .clk(clk), .rst(rst), .up_i(up), .dn_i(dn), .clr_i(clr_evt),
    .win_i(eff_dly), .tol_i(lock_tol), .span_i(lock_span),
    .viol_o(lock_viol), .locked_o(locked)
  );
endmodule

// File: rtl/pfd_checks.sv
module pfd_checks #(
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             up,
  input logic             dn,
  input logic             locked,
  input logic             ref_edge,
  input logic             fb_edge,
  input logic             pend_up,
  input logic             pend_dn,
  input logic             clr_evt,
  input logic             lock_viol,
  input logic [DLY_W-1:0] eff_dly
);
  logic [DLY_W:0] overlap;

  always_ff @(posedge clk) begin
    if (rst)           overlap <= '0;
    else if (up && dn) overlap <= overlap + 1'b1;
    else               overlap <= '0;
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> (!up && !dn && !locked));

  p_up_source_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(up) |-> ($past(ref_edge) || $past(pend_up)));

  p_dn_source_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(dn) |-> ($past(fb_edge) || $past(pend_dn)));

  p_clr_needs_both_r3: assert property (@(posedge clk) disable iff (rst)
    clr_evt |-> (up && dn));

  p_clr_drops_r3: assert property (@(posedge clk) disable iff (rst)
    clr_evt |=> (!up && !dn));

  p_overlap_window_r3: assert property (@(posedge clk) disable iff (rst)
    (up && dn) |-> (overlap < {1'b0, eff_dly}));

  p_held_edge_r8: assert property (@(posedge clk) disable iff (rst)
    pend_up |=> up);

  p_viol_unlock_r10: assert property (@(posedge clk) disable iff (rst)
    lock_viol |=> !locked);
endmodule

bind pfd_antibacklash pfd_checks #(.DLY_W(DLY_W)) u_checks (
  .clk(clk), .rst(rst), .up(up), .dn(dn), .locked(locked),
  .ref_edge(ref_edge), .fb_edge(fb_edge), .pend_up(pend_up), .pend_dn(pend_dn),
  .clr_evt(clr_evt), .lock_viol(lock_viol), .eff_dly(eff_dly)
);

// File: tb/pfd_antibacklash_tb.sv
module pfd_antibacklash_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        ref_in = 0, fb_in = 0;
  logic [7:0]  dly_cycles = 8'd3, lock_tol = 8'd2;
  logic [15:0] lock_span = 16'd4;
  logic        up, dn, locked;

  int checks = 0, fails = 0;
  int n_up = 0, n_dn = 0;
  string cur = "R2";

  // reference model state
  bit m_sr[3], m_sf[3];
  bit m_up, m_dn, m_pu, m_pd, m_lk;
  int m_age, m_ru, m_rd, m_lc;

  always #4 clk = ~clk;

  pfd_antibacklash u_dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .dly_cycles(dly_cycles), .lock_tol(lock_tol), .lock_span(lock_span),
    .up(up), .dn(dn), .locked(locked)
  );

  function automatic int win();
    return (dly_cycles == 0) ? 1 : int'(dly_cycles);
  endfunction

  function automatic int goal();
    return (lock_span == 0) ? 1 : int'(lock_span);
  endfunction

  function automatic void model_step(bit r, bit f);
    bit er, ef, both, clr, viol, nu, nd;
    if (rst) begin
      foreach (m_sr[i]) begin m_sr[i] = 0; m_sf[i] = 0; end
      {m_up, m_dn, m_pu, m_pd, m_lk} = '0;
      m_age = 0; m_ru = 0; m_rd = 0; m_lc = 0;
      return;
    end
    er   = m_sr[1] && !m_sr[2];
    ef   = m_sf[1] && !m_sf[2];
    both = m_up && m_dn;
    clr  = both && (m_age + 1 >= win());
    viol = (m_up && m_ru >= win() + int'(lock_tol)) || (m_dn && m_rd >= win() + int'(lock_tol));
    nu   = clr ? 1'b0 : (m_up || m_pu || er);
    nd   = clr ? 1'b0 : (m_dn || m_pd || ef);
    m_pu = clr && er;
    m_pd = clr && ef;
    m_age = (both && !clr) ? m_age + 1 : 0;
    m_ru = m_up ? ((m_ru < 1023) ? m_ru + 1 : m_ru) : 0;
    m_rd = m_dn ? ((m_rd < 1023) ? m_rd + 1 : m_rd) : 0;
    if (viol) begin
      m_lc = 0; m_lk = 0;
    end else if (clr) begin
      if (m_lc < goal()) m_lc++;
      m_lk = (m_lc >= goal());
    end
    m_up = nu; m_dn = nd;
    m_sr[2] = m_sr[1]; m_sr[1] = m_sr[0]; m_sr[0] = r;
    m_sf[2] = m_sf[1]; m_sf[1] = m_sf[0]; m_sf[0] = f;
  endfunction

  task automatic expect_int(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(bit r, bit f);
    ref_in = r; fb_in = f;
    @(posedge clk);
    @(negedge clk);
    model_step(r, f);
    checks++;
    if (up !== m_up || dn !== m_dn || locked !== m_lk) begin
      fails++;
      $display("FAIL %s cycle compare: actual up=%b dn=%b lk=%b expected up=%b dn=%b lk=%b",
               cur, up, dn, locked, m_up, m_dn, m_lk);
    end
    if (up) n_up++;
    if (dn) n_dn++;
  endtask

  task automatic do_reset(int d);
    rst = 1; dly_cycles = 8'(d);
    repeat (3) tick(0, 0);
    rst = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    // R1: reset state
    cur = "R1";
    do_reset(3);
    expect_int("R1", "up after reset", int'(up), 0);
    expect_int("R1", "dn after reset", int'(dn), 0);
    expect_int("R1", "locked after reset", int'(locked), 0);
    repeat (4) tick(0, 0);

    // R4/R9: aligned inputs, matched pulses, then lock
    cur = "R4";
    for (int p = 0; p < 8; p++) begin
      n_up = 0; n_dn = 0;
      for (int c = 0; c < 20; c++) tick(c < 10, c < 10);
    end
    expect_int("R4", "aligned up width", n_up, 3);
    expect_int("R4", "aligned dn width", n_dn, 3);
    expect_int("R9", "locked after aligned run", int'(locked), 1);

    // R5/R10: reference leads by 4
    cur = "R5";
    for (int p = 0; p < 3; p++) begin
      n_up = 0; n_dn = 0;
      for (int c = 0; c < 20; c++) tick(c < 10, c >= 4 && c < 14);
    end
    expect_int("R5", "lead up width", n_up, 7);
    expect_int("R5", "lead dn width", n_dn, 3);
    expect_int("R10", "locked after lead", int'(locked), 0);

    // R5: reference lags by 4
    for (int p = 0; p < 3; p++) begin
      n_up = 0; n_dn = 0;
      for (int c = 0; c < 20; c++) tick(c >= 4 && c < 14, c < 10);
    end
    expect_int("R5", "lag up width", n_up, 3);
    expect_int("R5", "lag dn width", n_dn, 7);

    // R6: reference three times faster
    cur = "R6";
    do_reset(3);
    n_up = 0; n_dn = 0;
    for (int c = 0; c < 96; c++) tick((c % 8) < 4, (c % 24) < 12);
    checks++;
    if (n_up <= 60 || n_dn >= 30) begin
      fails++;
      $display("FAIL R6 fast ref: actual up=%0d dn=%0d expected up>60 dn<30", n_up, n_dn);
    end

    // R7: edges inside a 6-cycle window are ignored
    cur = "R7";
    do_reset(6);
    for (int c = 0; c < 13; c++) tick(c == 0 || c == 2 || c == 4, 1);
    expect_int("R7", "up after masked edges", int'(up), 0);
    expect_int("R7", "dn after masked edges", int'(dn), 0);
    repeat (6) tick(0, 0);

    // R8: edge detected in the clearing cycle is kept
    cur = "R8";
    do_reset(3);
    for (int c = 0; c < 10; c++) tick(c == 0 || c >= 3, 1);
    expect_int("R8", "up re-raised", int'(up), 1);
    expect_int("R8", "dn stays low", int'(dn), 0);
    repeat (4) tick(0, 0);

    // R3: zero request acts as a one-cycle window
    cur = "R3";
    do_reset(0);
    for (int p = 0; p < 3; p++) begin
      n_up = 0; n_dn = 0;
      for (int c = 0; c < 12; c++) tick(c < 6, c < 6);
    end
    expect_int("R3", "window 0 up width", n_up, 1);
    expect_int("R3", "window 0 dn width", n_dn, 1);

    // R3: one-cycle window with offset inputs
    do_reset(1);
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 10; c++) tick(c < 5, c >= 2 && c < 7);

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule